// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

After a hard reset, this block reads the reset configuration table out of a boot memory and turns it into 32-bit configuration words. It runs a fixed series of single-byte reads over a plain read interface with an address, a read strobe, a data bus and a ready input. It uses only the least significant byte lane of every access, so the boot device can have any port width. Each run of four bytes becomes one word. The first word configures the local master. The other words are meant for up to seven slave devices.

When every read has been accepted, the block raises `done`. From then on it drives the master word and the reset vector address, and it returns any stored word through a 3-bit index port. The vector address is worked out from a single bit of the master word. No other configuration field is decoded here, and the block does not deliver the slave words to their devices.

Top module: `cfgf_fetch`

## Requirements
- R1: Every fetch makes exactly 32 accepted reads. Read k (k = 0..31) uses address 8·k. Once the last read is accepted, `mem_rd` stays low.
- R2: A pending read keeps `mem_rd` high and `mem_addr` unchanged until a clock edge at which `mem_ready` is high. That edge accepts the read.
- R3: The block takes bits [7:0] of `mem_rdata` from each accepted read. Bits above 7 have no effect on any output.
- R4: Accepted reads 4w..4w+3 build word w. The byte from read 4w goes to bits [31:24], the next to [23:16], the next to [15:8], and the byte from read 4w+3 goes to [7:0].
- R5: Word 0 appears on `master_word`. When `slave_idx` = n with n in 1..7, `slave_word` returns word n. When `slave_idx` = 0, it returns word 0.
- R6: When `done` is high, `vector_addr` is 0x00000100 if bit 17 of the master word is 0, and 0xFFF00100 if that bit is 1.
- R7: `done` goes high at the clock edge that accepts the 32nd read. After that, `done`, `master_word` and `vector_addr` hold their values until the next reset. While `done` is low, `master_word`, `vector_addr` and `slave_word` read 0.
- R8: Asserting `rst_n` low in the middle of a fetch clears `done` and all collected bytes at once and returns `mem_addr` to 0. After release, the fetch starts again from address 0 and uses only the data read after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address of the current read |
| mem_rd | output | 1 | Read strobe, high while a read is pending |
| mem_rdata | input | 64 | Boot memory data; only bits [7:0] are used |
| mem_ready | input | 1 | Memory accepts the pending read at this edge |
| done | output | 1 | All words collected |
| master_word | output | 32 | Master configuration word (0 before done) |
| vector_addr | output | 32 | Reset vector address (0 before done) |
| slave_idx | input | 3 | Word index for the read port |
| slave_word | output | 32 | Word selected by slave_idx (0 before done) |

## Verification
The only registers on the path from a read to the outputs are the byte store and the `done` flag. A byte therefore lands in the store at the edge that sees `mem_ready` high. `done`, `master_word` and `vector_addr` change at the edge that accepts the 32nd read. `slave_word` follows `slave_idx` in the same cycle with no added latency. The bench drives `mem_ready` and the data at falling edges and checks the address when it drives ready. It reads results at the next falling edge after the accepting rising edge, and it samples `slave_word` one nanosecond after changing the index. Reset acts asynchronously, so `mem_addr` and `done` are checked one nanosecond after `rst_n` falls.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;
   localparam int unsigned CFG_W          = 32;
   localparam int unsigned BYTES_PER_WORD = 4;
   localparam logic [31:0] VEC_BASE_LO    = 32'h0000_0000;
   localparam logic [31:0] VEC_BASE_HI    = 32'hFFF0_0000;
   localparam logic [31:0] VEC_OFFSET     = 32'h0000_0100;
   typedef logic [CFG_W-1:0] cfg_word_t;
endpackage

// File: rtl/cfgf_seq.sv
// Read sequencer: one read index drives both the address and the byte slot.
module cfgf_seq #(
   parameter int unsigned TOTAL  = 32,
   parameter int unsigned STRIDE = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_ready,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CNT_W-1:0]  rd_idx,
   output logic              take,
   output logic              done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

   logic [CNT_W-1:0] idx_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         done_q <= 1'b0;
      end else if (take) begin
         if (idx_q == LAST) done_q <= 1'b1;
         else               idx_q  <= idx_q + 1'b1;
      end
   end

   assign mem_rd   = ~done_q;
   assign take     = mem_rd & mem_ready;
   assign mem_addr = ADDR_W'(idx_q) * ADDR_W'(STRIDE);
   assign rd_idx   = idx_q;
   assign done     = done_q;
endmodule

// File: rtl/cfgf_pack.sv
// Byte packer: places the low lane byte into its word, first byte most significant.
module cfgf_pack #(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned DATA_W    = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        take,
   input  logic [CNT_W-1:0]            rd_idx,
   input  logic [DATA_W-1:0]           rdata,
   output logic [NUM_WORDS-1:0][31:0]  words
);
   localparam int unsigned WI_W = CNT_W - 2;

   logic [7:0]      lane;
   logic [WI_W-1:0] widx;
   logic [1:0]      bpos;

   generate
      if (DATA_W == 8) begin : g_narrow
         assign lane = rdata;
      end else begin : g_wide
         assign lane = rdata[7:0];
      end
   endgenerate

   assign widx = rd_idx[CNT_W-1:2];
   assign bpos = rd_idx[1:0];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (take && (widx == WI_W'(w)))
            word_q[{~bpos, 3'b000} +: 8] <= lane;
      end
      assign words[w] = word_q;
   end
endmodule

// File: rtl/cfgf_vec.sv
// Reset vector: base chosen by one master-word bit, plus the fixed reset offset.
module cfgf_vec
   import cfgf_pkg::*;
#(
   parameter int unsigned SEL_BIT = 17
) (
   input  cfg_word_t master,
   input  logic      valid,
   output cfg_word_t vec
);
   generate
      if (SEL_BIT >= CFG_W) begin : g_bad_sel
         $error("cfgf_vec: SEL_BIT outside the configuration word");
      end
   endgenerate

   cfg_word_t base;
   assign base = master[SEL_BIT] ? VEC_BASE_HI : VEC_BASE_LO;
   assign vec  = valid ? (base + VEC_OFFSET) : '0;
endmodule

// File: rtl/cfgf_fetch.sv
module cfgf_fetch
   import cfgf_pkg::*;
#(
   parameter int unsigned NUM_WORDS   = 8,
   parameter int unsigned BYTE_STRIDE = 8,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned VEC_SEL_BIT = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done,
   output logic [31:0]       master_word,
   output logic [31:0]       vector_addr,
   input  logic [2:0]        slave_idx,
   output logic [31:0]       slave_word
);
   localparam int unsigned TOTAL_READS = NUM_WORDS * BYTES_PER_WORD;
   localparam int unsigned CNT_W       = $clog2(TOTAL_READS);

   generate
      if (NUM_WORDS < 2 || NUM_WORDS > 8) begin : g_bad_words
         $error("cfgf_fetch: NUM_WORDS must lie in 2..8");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("cfgf_fetch: DATA_W narrower than one byte lane");
      end
      if (BYTE_STRIDE == 0) begin : g_bad_stride
         $error("cfgf_fetch: BYTE_STRIDE must be non-zero");
      end
   endgenerate

   logic [CNT_W-1:0]           rd_idx;
   logic                       take;
   logic [NUM_WORDS-1:0][31:0] words;

   cfgf_seq #(
      .TOTAL (TOTAL_READS),
      .STRIDE(BYTE_STRIDE),
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_ready(mem_ready),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .rd_idx   (rd_idx),
      .take     (take),
      .done     (done)
   );

   cfgf_pack #(
      .NUM_WORDS(NUM_WORDS),
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W)
   ) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .rd_idx(rd_idx),
      .rdata (mem_rdata),
      .words (words)
   );

   cfgf_vec #(
      .SEL_BIT(VEC_SEL_BIT)
   ) u_vec (
      .master(words[0]),
      .valid (done),
      .vec   (vector_addr)
   );

   assign master_word = done ? words[0] : '0;

   always_comb begin
      slave_word = '0;
      if (done) begin
         for (int k = 0; k < NUM_WORDS; k++) begin
            if (slave_idx == 3'(k)) slave_word = words[k];
         end
      end
   end
endmodule

// File: rtl/cfgf_chk.sv
module cfgf_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BYTE_STRIDE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_ready,
   input logic              done,
   input logic [31:0]       master_word,
   input logic [31:0]       vector_addr
);
   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ready) |=> (done || (mem_addr == $past(mem_addr) + ADDR_W'(BYTE_STRIDE)))); // R1

   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> ((mem_addr % ADDR_W'(BYTE_STRIDE)) == '0)); // R1

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(master_word) && $stable(vector_addr))); // R7

   AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((vector_addr == 32'h0000_0100) || (vector_addr == 32'hFFF0_0100))); // R6
endmodule

bind cfgf_fetch cfgf_chk #(
   .ADDR_W     (ADDR_W),
   .BYTE_STRIDE(BYTE_STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_addr   (mem_addr),
   .mem_rd     (mem_rd),
   .mem_ready  (mem_ready),
   .done       (done),
   .master_word(master_word),
   .vector_addr(vector_addr)
);

// File: tb/cfgf_fetch_test.sv
`timescale 1ns/1ps
module cfgf_fetch_test;
   localparam int TOTAL = 32;
   localparam int VSEL  = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic [63:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        done;
   logic [31:0] master_word;
   logic [31:0] vector_addr;
   logic [2:0]  slave_idx = 3'd0;
   logic [31:0] slave_word;

   always #2 clk = ~clk;

   cfgf_fetch uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
      .master_word(master_word), .vector_addr(vector_addr),
      .slave_idx(slave_idx), .slave_word(slave_word)
   );

   logic [7:0]  img [TOTAL];
   int          n_chk = 0, n_fail = 0;
   int          wait_fix = 0;
   bit          wait_alt = 1'b0;
   int          acc_cnt = 0, addr_err = 0, hold_err = 0, wcnt = 0;
   bit          pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          cycles = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Memory model: drives ready and data at falling edges, logs accepted reads.
   always @(negedge clk) begin
      int need;
      if (!rst_n || !mem_rd) begin
         mem_ready = 1'b0; wcnt = 0; pend = 1'b0;
      end else begin
         if (pend && mem_addr != pend_addr) hold_err++;
         need = wait_alt ? ((acc_cnt % 2 == 1) ? 3 : 0) : wait_fix;
         if (wcnt >= need) begin
            if (mem_addr != 32'(acc_cnt * 8)) addr_err++;
            mem_rdata = {56'hA5_5A_C3_3C_96_69_F0 ^ 56'(mem_addr),
                         (mem_addr / 8 < TOTAL) ? img[mem_addr / 8] : 8'h00};
            mem_ready = 1'b1; acc_cnt++; wcnt = 0; pend = 1'b0;
         end else begin
            mem_ready = 1'b0; wcnt++; pend = 1'b1; pend_addr = mem_addr;
            mem_rdata = ~64'h0;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [31:0] exp_word(input int w);
      return {img[4*w], img[4*w+1], img[4*w+2], img[4*w+3]};
   endfunction

   function automatic logic [31:0] exp_vec();
      logic [31:0] m = exp_word(0);
      return m[VSEL] ? 32'hFFF0_0100 : 32'h0000_0100;
   endfunction

   task automatic build_img(input int seed, input bit vbit);
      for (int i = 0; i < TOTAL; i++) img[i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 4));
      img[1][1] = vbit; // master bit 17 sits in bit 1 of the second byte
   endtask

   task automatic clear_log();
      acc_cnt = 0; addr_err = 0; hold_err = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); #1 rst_n = 1'b0;
      clear_log();
      repeat (2) @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wait_done(input string req);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) return;
      end
      chk(1'b0, req, "done timeout", {31'd0, done}, 32'd1);
   endtask

   task automatic check_words(input string tag);
      chk(master_word == exp_word(0), "R4", {tag, " master word"}, master_word, exp_word(0));
      for (int n = 0; n < 8; n++) begin
         slave_idx = 3'(n); #1;
         chk(slave_word == exp_word(n), "R5", $sformatf("%s index %0d", tag, n), slave_word, exp_word(n));
      end
      chk(vector_addr == exp_vec(), "R6", {tag, " vector"}, vector_addr, exp_vec());
   endtask

   task automatic t_reset_state();
      build_img(1, 1'b0);
      wait_fix = 0; wait_alt = 1'b0;
      @(negedge clk); #1;
      chk(done == 1'b0, "R7", "done in reset", {31'd0, done}, 32'd0);
      chk(master_word == 32'd0, "R7", "master in reset", master_word, 32'd0);
      chk(mem_addr == 32'd0, "R1", "address in reset", mem_addr, 32'd0);
      chk(mem_rd == 1'b1, "R1", "strobe in reset", {31'd0, mem_rd}, 32'd1);
   endtask

   task automatic t_fetch(input string tag, input int seed, input bit vbit,
                          input int wfix, input bit walt);
      logic [31:0] m0, v0;
      build_img(seed, vbit);
      wait_fix = wfix; wait_alt = walt;
      do_reset();
      while (acc_cnt < 10) @(negedge clk);
      slave_idx = 3'd3; #1;
      chk(master_word == 0 && vector_addr == 0 && slave_word == 0, "R7",
          {tag, " outputs zero before done"}, master_word | vector_addr | slave_word, 32'd0);
      wait_done("R7");
      chk(acc_cnt == TOTAL, "R1", {tag, " read count"}, 32'(acc_cnt), 32'(TOTAL));
      chk(addr_err == 0, "R1", {tag, " address sequence"}, 32'(addr_err), 32'd0);
      chk(hold_err == 0, "R2", {tag, " address held while waiting"}, 32'(hold_err), 32'd0);
      check_words(tag); // upper lanes carry non-zero junk: R3
      m0 = master_word; v0 = vector_addr;
      repeat (20) @(negedge clk);
      chk(done && master_word == m0 && vector_addr == v0, "R7", {tag, " stable after done"},
          master_word, m0);
      chk(mem_rd == 1'b0 && acc_cnt == TOTAL, "R1", {tag, " no reads after done"},
          32'(acc_cnt), 32'(TOTAL));
   endtask

   task automatic t_restart();
      build_img(7, 1'b1);
      wait_fix = 1; wait_alt = 1'b0;
      do_reset();
      while (acc_cnt < 13) @(negedge clk);
      #1 rst_n = 1'b0; #1;
      chk(mem_addr == 32'd0 && done == 1'b0, "R8", "address back to zero in reset", mem_addr, 32'd0);
      build_img(9, 1'b0);
      clear_log();
      repeat (2) @(negedge clk);
      #1 rst_n = 1'b1;
      wait_done("R8");
      chk(acc_cnt == TOTAL, "R8", "restart read count", 32'(acc_cnt), 32'(TOTAL));
      chk(addr_err == 0, "R8", "restart from address zero", 32'(addr_err), 32'd0);
      check_words("restart R8");
   endtask

   initial begin
      t_reset_state();
      t_fetch("zero-wait", 3, 1'b0, 0, 1'b0);
      t_fetch("two-wait", 5, 1'b1, 2, 1'b0);
      t_fetch("mixed-wait", 11, 1'b1, 0, 1'b1);
      t_restart();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule